// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus: a serial clock (MDC) and a bidirectional data line (MDIO). Software loads one 32-bit frame word, and that single write starts a complete Clause 22 transaction. Unless software disables it, the controller sends a run of 32 ones as a preamble. It then shifts the frame out MSB first. On a read it releases the data line at the turnaround and shifts in the PHY's 16-bit reply. When the last bit period closes, the reply is written into the low half of the same frame word. A sticky completion flag is then set and, if enabled by a mask bit, drives the interrupt line.

A configuration register sets three things. The first is the MDC half-period in system clocks. The second is how long after each falling MDC edge the data line may change. The third is whether the preamble is skipped. The data line appears as separate out, enable and in pins so that a pad or test model can resolve it.

Register map (regAddr): 0 = FRAME, 1 = EVENT, 2 = MASK, 3 = CTRL. FRAME layout: start code [31:30] (software writes 01), opcode [29:28] (10 read, 01 write), PHY address [27:23], register address [22:18], turnaround [17:16] (software writes 10), data [15:0]. EVENT: bit 0 done, bit 1 busy. MASK: bit 0. CTRL: speed [5:0], hold [10:8], no-preamble [12].

Top module: `mdio_master`

## Requirements
- R1: A write to FRAME (regAddr 0) while idle starts a transaction that places all 32 frame bits on mdioOut, MSB (bit 31) first, one bit per MDC period, each valid at the MDC rising edge.
- R2: With CTRL[12] = 0 the frame is preceded by 32 MDC periods with mdioOut = 1 and mdioOe = 1; with CTRL[12] = 1 the frame bits start at the first MDC period.
- R3: With speed S = CTRL[5:0] > 0, MDC is low for S+1 system clocks and then high for S+1 system clocks per bit. The done flag becomes visible N·2·(S+1) clock edges after the edge that accepted the FRAME write, where N is 64 with preamble and 32 without.
- R4: With S = 0, MDC does not toggle and an accepted transaction stays busy until a non-zero speed is written, after which it completes normally.
- R5: mdioOut and mdioOe change only in the MDC low phase, H+1 system clocks after the falling MDC edge. H = min(CTRL[10:8], S-1).
- R6: When opcode FRAME[29:28] = 10, mdioOe is 0 from frame bit 14 (the first turnaround bit) through the end. mdioIn is sampled at the MDC rising edge of each of the 16 data bits, and the result, first-received bit in position 15, replaces FRAME[15:0] when the transaction finishes, leaving FRAME[31:16] unchanged.
- R7: EVENT[1] reads 1 while a transaction is in progress, and a FRAME write during that time is ignored: FRAME reads back and is sent as the earlier word.
- R8: EVENT[0] is set when a transaction finishes. Writing EVENT with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it set.
- R9: irq is 1 exactly when EVENT[0] = 1 and MASK[0] = 1.
- R10: After reset and after each transaction finishes, mdc is 0 and mdioOe is 0. After reset, all registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 FRAME, 1 EVENT, 2 MASK, 3 CTRL |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| mdc | output | 1 | Management bus clock |
| mdioOut | output | 1 | Data line value when driven |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data line value seen at the pin |
| irq | output | 1 | Completion interrupt |

## Verification
Every delay in this block is a whole number of system clocks set by the speed and hold fields. The bench therefore predicts each event from the CTRL value it wrote: done after N·2·(S+1) edges, each data-line change H+1 clocks after the MDC fall, and read data with the done flag. It counts edges from the accepting write and samples a fixed offset after each edge, never on it. Serial bits are captured on the MDC rising edge, when they are guaranteed stable. The response bits are driven on the falling edge, half a bit period before the controller samples them. Register effects such as the clear, the mask and an ignored FRAME write are read back one cycle after the write edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int OP_LSB  = 28;
  localparam int TA_POS  = 14;  // frame bit (counted from the MSB) where turnaround starts
  localparam int DATA_POS = 16; // frame bit where the data field starts
  localparam int HOLD_LSB = 8;
  localparam int NOPRE_BIT = 12;

  localparam logic [1:0] ADDR_FRAME = 2'd0;
  localparam logic [1:0] ADDR_EVENT = 2'd1;
  localparam logic [1:0] ADDR_MASK  = 2'd2;
  localparam logic [1:0] ADDR_CTRL  = 2'd3;
  localparam logic [1:0] OP_READ    = 2'b10;

  typedef struct packed {
    logic load;      // accept a new frame word
    logic drive;     // update the data line outputs
    logic drivePre;  // current bit belongs to the preamble
    logic driveEn;   // enable value for the current bit
    logic sample;    // capture mdioIn
    logic finish;    // last bit period has closed
  } mdio_strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int HOLD_W  = 3,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              frameRead,
  output mdio_strobe_t      strobe,
  output logic              mdc,
  output logic              busy,
  output logic              doneFlag,
  output logic              maskBit,
  output logic [DIV_W-1:0]  speedCfg,
  output logic [HOLD_W-1:0] holdCfg,
  output logic              noPre
);
  localparam int TOTAL = PRE_LEN + FRAME_W;
  localparam int BIT_W = $clog2(TOTAL);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(TOTAL - 1);
  localparam logic [BIT_W-1:0] PRE_IDX  = BIT_W'(PRE_LEN);

  logic [DIV_W-1:0] phaseCnt;
  logic [DIV_W-1:0] holdExt;
  logic [DIV_W-1:0] holdPt;
  logic [BIT_W-1:0] bitIdx;
  logic [BIT_W-1:0] frameBit;
  logic             mdcQ;
  logic             running;
  logic             phaseEnd;
  logic             inPre;
  logic             lastBit;
  logic             wrFrame;
  logic             unusedData;

  assign unusedData = ^regWrData;
  assign wrFrame  = regWrEn && (regAddr == ADDR_FRAME);
  assign running  = busy && (speedCfg != '0);
  assign phaseEnd = running && (phaseCnt >= speedCfg);
  assign inPre    = bitIdx < PRE_IDX;
  assign frameBit = bitIdx - PRE_IDX;
  assign lastBit  = bitIdx == LAST_IDX;
  assign holdExt  = DIV_W'(holdCfg);
  assign holdPt   = (holdExt < speedCfg) ? holdExt : speedCfg - 1'b1;
  assign mdc      = mdcQ;

  always_comb begin
    strobe          = '0;
    strobe.load     = wrFrame && !busy;
    strobe.drive    = running && !mdcQ && (phaseCnt == holdPt);
    strobe.drivePre = inPre;
    strobe.driveEn  = inPre || !frameRead || (frameBit < BIT_W'(TA_POS));
    strobe.sample   = phaseEnd && !mdcQ && frameRead && !inPre &&
                      (frameBit >= BIT_W'(DATA_POS));
    strobe.finish   = phaseEnd && mdcQ && lastBit;
  end

  // Bit sequencing and MDC generation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mdcQ     <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (strobe.load) begin
      busy     <= 1'b1;
      mdcQ     <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= noPre ? PRE_IDX : '0;
    end else if (running) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        mdcQ     <= ~mdcQ;
        if (mdcQ) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  // Configuration, event and mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speedCfg <= '0;
      holdCfg  <= '0;
      noPre    <= 1'b0;
      doneFlag <= 1'b0;
      maskBit  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) begin
        speedCfg <= regWrData[DIV_W-1:0];
        holdCfg  <= regWrData[HOLD_LSB +: HOLD_W];
        noPre    <= regWrData[NOPRE_BIT];
      end
      if (regWrEn && regAddr == ADDR_MASK) maskBit <= regWrData[0];
      if (strobe.finish) doneFlag <= 1'b1;
      else if (regWrEn && regAddr == ADDR_EVENT && regWrData[0]) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  mdio_strobe_t       strobe,
  input  logic [FRAME_W-1:0] wrData,
  input  logic               mdioIn,
  output logic [FRAME_W-1:0] frameWord,
  output logic               frameRead,
  output logic               mdioOut,
  output logic               mdioOe
);
  logic [FRAME_W-1:0] shiftQ;
  logic [DATA_W-1:0]  rxQ;

  assign frameRead = frameWord[OP_LSB +: 2] == OP_READ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameWord <= '0;
      shiftQ    <= '0;
      rxQ       <= '0;
      mdioOut   <= 1'b0;
      mdioOe    <= 1'b0;
    end else begin
      if (strobe.load) begin
        frameWord <= wrData;
        shiftQ    <= wrData;
      end
      if (strobe.drive) begin
        mdioOut <= strobe.drivePre ? 1'b1 : shiftQ[FRAME_W-1];
        mdioOe  <= strobe.driveEn;
        if (!strobe.drivePre) shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
      end
      if (strobe.sample) rxQ <= {rxQ[DATA_W-2:0], mdioIn};
      if (strobe.finish) begin
        mdioOe <= 1'b0;
        if (frameRead) frameWord[DATA_W-1:0] <= rxQ;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int HOLD_W  = 3,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn,
  output logic        irq
);
  mdio_strobe_t       strobe;
  logic               busy;
  logic               doneFlag;
  logic               maskBit;
  logic               noPre;
  logic               frameRead;
  logic [DIV_W-1:0]   speedCfg;
  logic [HOLD_W-1:0]  holdCfg;
  logic [FRAME_W-1:0] frameWord;

  mdio_ctrl #(.DIV_W(DIV_W), .HOLD_W(HOLD_W), .PRE_LEN(PRE_LEN)) ctrl (
    .clk, .rst_n, .regAddr, .regWrEn, .regWrData, .frameRead, .strobe, .mdc,
    .busy, .doneFlag, .maskBit, .speedCfg, .holdCfg, .noPre
  );

  mdio_dpath dpath (
    .clk, .rst_n, .strobe, .wrData(regWrData), .mdioIn, .frameWord,
    .frameRead, .mdioOut, .mdioOe
  );

  assign irq = doneFlag & maskBit;

  always_comb begin
    case (regAddr)
      ADDR_FRAME: regRdData = frameWord;
      ADDR_EVENT: regRdData = {30'd0, busy, doneFlag};
      ADDR_MASK:  regRdData = {31'd0, maskBit};
      default:    regRdData = 32'(speedCfg) | (32'(holdCfg) << HOLD_LSB) |
                              (32'(noPre) << NOPRE_BIT);
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mdc,
  input logic               mdioOut,
  input logic               mdioOe,
  input logic               irq,
  input logic               busy,
  input logic               doneFlag,
  input logic               maskBit,
  input logic [DIV_W-1:0]   speedCfg,
  input logic [FRAME_W-1:0] frameWord,
  input logic               regWrEn,
  input logic [1:0]         regAddr
);
  AST_OUT_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe))); // R5

  AST_SPEED_ZERO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((speedCfg == '0) && $past(speedCfg == '0)) |-> $stable(mdc)); // R4

  AST_BUSY_FRAME_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdc && regWrEn && regAddr == ADDR_FRAME) |=> $stable(frameWord)); // R7

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> doneFlag); // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdioOe)); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !maskBit |-> !irq); // R9
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) chk (.*);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  import mdio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, irq;
  logic        mdioIn = 1'b1;

  mdio_master uut (.*);

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY-side responder and bit capture
  int          rises = 0;
  int          preCnt = 32;
  logic [63:0] capOut = '0;
  logic [63:0] capOe = '0;
  logic [15:0] rdPat = '0;

  always @(posedge mdc) begin
    capOut = {capOut[62:0], mdioOut};
    capOe  = {capOe[62:0], mdioOe};
    rises++;
  end

  always @(negedge mdc) begin
    int idx;
    idx = rises - preCnt - 16;
    mdioIn = (idx >= 0 && idx < 16) ? rdPat[15-idx] : 1'b1;
  end

  // Hold-time monitor: each data-line change after a driven bit is H+1 clocks past the MDC fall
  logic prevMdc = 1'b0, prevOut = 1'b0, prevOe = 1'b0;
  int   sinceFall = 0;
  int   expHold = 0;
  always @(negedge clk) begin
    if (prevMdc && !mdc) sinceFall = 0;
    else begin
      sinceFall++;
      if (prevOe && (mdioOut !== prevOut || mdioOe !== prevOe))
        check(sinceFall == expHold + 1, "R5", "clocks from MDC fall to line change",
              64'(sinceFall), 64'(expHold + 1));
    end
    prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] ctrlWord(input int spd, input int hld, input bit np);
    return 32'(spd) | (32'(hld) << 8) | (32'(np) << 12);
  endfunction

  function automatic logic [31:0] mkFrame(input bit rd, input logic [4:0] pa,
                                          input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
  endfunction

  // Wait for the done flag, returning the number of edges since the accepting write
  task automatic waitDone(output int c);
    c = 0;
    regAddr = ADDR_EVENT;
    do begin
      @(posedge clk); c++;
      #1;
    end while (!regRdData[0] && c < 20000);
  endtask

  task automatic runTxn(input logic [31:0] frame, input int spd, input int hld,
                        input bit np, input logic [15:0] pat);
    int c, n;
    logic [31:0] rd;
    logic [63:0] nMask, expOut, expOe, outMask;
    bit isRd;
    regWrite(ADDR_CTRL, ctrlWord(spd, hld, np));
    expHold = (hld < spd) ? hld : spd - 1;
    preCnt = np ? 0 : 32;
    rdPat = pat; rises = 0; capOut = '0; capOe = '0;
    isRd = frame[29:28] == 2'b10;
    n = preCnt + 32;
    nMask = (n == 64) ? '1 : ((64'd1 << n) - 1);
    expOut = ({32'hFFFF_FFFF, frame}) & nMask;
    expOe = nMask & ~(isRd ? 64'h3FFFF : 64'h0);
    outMask = nMask & ~(isRd ? 64'h3FFFF : 64'h0);
    regWrite(ADDR_FRAME, frame);
    waitDone(c);
    check(c == n * 2 * (spd + 1), "R3", "edges to done", 64'(c), 64'(n * 2 * (spd + 1)));
    check(rises == n, "R2", "MDC periods per frame", 64'(rises), 64'(n));
    check((capOut & outMask) == (expOut & outMask), "R1", "bits sent on MDIO",
          capOut & outMask, expOut & outMask);
    check(capOe == expOe, "R6", "drive-enable pattern", capOe, expOe);
    regRead(ADDR_FRAME, rd);
    check(rd == (isRd ? {frame[31:16], pat} : frame), "R6", "frame readback",
          64'(rd), 64'(isRd ? {frame[31:16], pat} : frame));
    regRead(ADDR_EVENT, rd);
    check(rd[1:0] == 2'b01, "R8", "event after finish", 64'(rd[1:0]), 64'h1);
    check(!mdc && !mdioOe, "R10", "bus released", {62'd0, mdc, mdioOe}, 64'd0);
    regWrite(ADDR_EVENT, 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] fa;
    int c;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    check(!mdc && !mdioOe && !irq, "R10", "pins after reset", {61'd0, mdc, mdioOe, irq}, 64'd0);
    regRead(ADDR_FRAME, rd); check(rd == 0, "R10", "FRAME after reset", 64'(rd), 64'd0);
    regRead(ADDR_EVENT, rd); check(rd == 0, "R10", "EVENT after reset", 64'(rd), 64'd0);
    regRead(ADDR_CTRL, rd);  check(rd == 0, "R10", "CTRL after reset", 64'(rd), 64'd0);

    // Directed: write with preamble, read, no-preamble, clamped hold
    runTxn(mkFrame(1'b0, 5'h13, 5'h0A, 16'hBEEF), 2, 1, 1'b0, 16'h0);
    runTxn(mkFrame(1'b1, 5'h01, 5'h1F, 16'h0000), 3, 2, 1'b0, 16'hA5C3);
    runTxn(mkFrame(1'b1, 5'h1F, 5'h00, 16'h0000), 1, 0, 1'b1, 16'h8001);
    runTxn(mkFrame(1'b0, 5'h00, 5'h15, 16'h5555), 2, 5, 1'b1, 16'h0);

    // R7: frame write while busy is ignored
    fa = mkFrame(1'b0, 5'h0C, 5'h03, 16'h1234);
    regWrite(ADDR_CTRL, ctrlWord(3, 1, 1'b1));
    expHold = 1; preCnt = 0; rises = 0; capOut = '0; capOe = '0;
    regWrite(ADDR_FRAME, fa);
    repeat (20) @(posedge clk);
    regWrite(ADDR_FRAME, mkFrame(1'b1, 5'h11, 5'h11, 16'hFFFF));
    regRead(ADDR_FRAME, rd); check(rd == fa, "R7", "FRAME kept while busy", 64'(rd), 64'(fa));
    regRead(ADDR_EVENT, rd); check(rd[1] == 1'b1, "R7", "busy bit", 64'(rd[1]), 64'd1);
    waitDone(c);
    check(capOut[31:0] == fa, "R7", "earlier frame sent", 64'(capOut[31:0]), 64'(fa));

    // R8 / R9: clear semantics and interrupt gating
    check(!irq, "R9", "irq masked", 64'(irq), 64'd0);
    regWrite(ADDR_EVENT, 32'd0);
    regRead(ADDR_EVENT, rd); check(rd[0] == 1'b1, "R8", "write 0 keeps done", 64'(rd[0]), 64'd1);
    regWrite(ADDR_MASK, 32'd1);
    #1 check(irq, "R9", "irq with done and mask", 64'(irq), 64'd1);
    regWrite(ADDR_MASK, 32'd0);
    #1 check(!irq, "R9", "irq with mask off", 64'(irq), 64'd0);
    regWrite(ADDR_MASK, 32'd1);
    regWrite(ADDR_EVENT, 32'd1);
    regRead(ADDR_EVENT, rd); check(rd[0] == 1'b0, "R8", "write 1 clears done", 64'(rd[0]), 64'd0);
    check(!irq, "R9", "irq after clear", 64'(irq), 64'd0);
    regWrite(ADDR_MASK, 32'd0);

    // R4: speed zero stalls MDC, resumes after a non-zero speed
    regWrite(ADDR_CTRL, ctrlWord(0, 0, 1'b0));
    preCnt = 32; rises = 0;
    regWrite(ADDR_FRAME, mkFrame(1'b0, 5'h02, 5'h04, 16'h00FF));
    repeat (60) @(posedge clk);
    #1 check(rises == 0 && !mdc, "R4", "MDC rises at speed 0", 64'(rises), 64'd0);
    regRead(ADDR_EVENT, rd); check(rd[1:0] == 2'b10, "R4", "still busy", 64'(rd[1:0]), 64'h2);
    expHold = 0;
    regWrite(ADDR_CTRL, ctrlWord(1, 0, 1'b0));
    waitDone(c);
    check(c == 64 * 4, "R4", "edges after speed set", 64'(c), 64'(64 * 4));
    check(rises == 64, "R4", "periods after resume", 64'(rises), 64'd64);
    regWrite(ADDR_EVENT, 32'd1);

    // Random transactions
    for (int i = 0; i < 8; i++) begin
      runTxn(mkFrame(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom)),
             1 + int'($urandom % 4), int'($urandom % 8), 1'($urandom % 2), 16'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule